// File: doc/BRIEF.md
# Keyed Watchdog Timer with Configuration Lock

This block is a watchdog for a processor subsystem. It has one 32-bit control register. A free-running prescaler divides the clock into ticks, and a tick counter advances on each tick while the watchdog is enabled. Software must restart the counter before it overflows. If it does not, the configured action fires. In interrupt mode that action is a one-cycle interrupt pulse. In reset mode it is a held request to the system reset generator. The reset generator itself lives outside this block and answers by pulsing the system reset input.

A write changes anything only when the top half of the write data carries the 16-bit key 0xCA36; any other write is dropped whole. Software can set a lock bit, after which the configuration stays frozen until the next system reset. Two write-only strobes are available: one restarts the counter and one forces the timeout action at once. Two further bits control stalling. One lets the counter keep running while the processor is halted by a debugger. The other pauses the counter while the processor sleeps. Two status bits can be read: a half-way flag and a reset-cause flag. The reset-cause flag survives the reset it reports and is cleared only by an external reset.

The block uses two resets. `rst_ext_n` is the external (power-on or pin) reset, and the environment asserts `rst_sys_n` together with it. `rst_sys_n` is the full system reset, which also follows every watchdog reset request.

Top module: `wdt_guard`

## Requirements
- R1: After an external reset the control word reads 0 and both `wdt_irq` and `wdt_rst_req` are low.
- R2: A write whose bits [31:16] differ from 0xCA36 leaves the control word unchanged. Bits [31:16] of the control word always read 0.
- R3: Control word layout:
  - bit 0: enable
  - bits [3:1]: prescaler select
  - bit 4: action, where 1 requests a reset and 0 raises an interrupt
  - bit 9: run while halted in debug
  - bit 11: pause while asleep

  Each of these fields reads back what was written. The restart strobe (bit 6) and the force strobe (bit 7) always read 0.
- R4: The prescaler select s maps to a shift t: s = 0..7 gives t = 1, 2, 3, 6, 7, 10, 11, 12. A timeout fires exactly 2^(CNT_W+t) clock edges after the write that enabled the watchdog or restarted it.
- R5: With the action bit at 0, a timeout gives a `wdt_irq` pulse one cycle long. The counter then wraps and keeps going, so the next pulse follows one full period later.
- R6: With the action bit at 1, a timeout raises `wdt_rst_req`, which stays high until `rst_sys_n` is asserted. At the same edge, reset-cause bit 5 becomes 1. A system reset does not clear bit 5; an external reset does.
- R7: A keyed write with bit 6 set clears the counter, which postpones the timeout by a full period.
- R8: A keyed write that sets bit 7 and leaves the watchdog enabled fires the configured action at the edge of that write.
- R9: Once lock bit 8 is set, every write is ignored until `rst_sys_n` is asserted. Asserting `rst_sys_n` clears the lock.
- R10: While `dbg_halt` is high and bit 9 is 0, the counter does not advance. While bit 9 is 1, the counter advances normally.
- R11: While `cpu_sleep` is high and bit 11 is 1, the counter does not advance.
- R12: Read-only bit 10 is 1 once the counter has reached half of its range, which happens 2^(CNT_W-1+t) edges after a restart.
- R13: A keyed write that clears enable also clears the counter. Re-enabling then starts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ext_n | input | 1 | External reset, active low, asynchronous |
| rst_sys_n | input | 1 | System reset (external or watchdog), active low, asynchronous |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data including the key |
| ctrl_rdata | output | 32 | Control register read value |
| dbg_halt | input | 1 | Processor is halted by a debugger |
| cpu_sleep | input | 1 | Processor is in sleep mode |
| wdt_irq | output | 1 | Timeout interrupt pulse |
| wdt_rst_req | output | 1 | Held request to the system reset generator |

## Verification
Several properties are checked on every cycle:
- Unkeyed writes and writes issued while locked never disturb the stored configuration.
- The lock is sticky.
- A reset request is held until the system reset arrives, and the cause flag is already set whenever it is raised.
- The counter stays still while stalled and is zero while disabled.
- An interrupt appears only in interrupt mode.

The exact timeout period for each prescaler setting, wrap-around to a second pulse, how far a restart postpones the timeout, the half-way flag timing, and the cause flag surviving a system reset can only be shown by the bench's timed scenarios.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

   localparam int unsigned CTRL_W   = 32;
   localparam int unsigned KEY_W    = 16;
   localparam int unsigned KEY_LSB  = 16;
   localparam int unsigned PSEL_W   = 3;
   localparam int unsigned NUM_SEL  = 1 << PSEL_W;
   localparam int unsigned MAX_TAP  = 12;

   localparam int unsigned B_EN      = 0;
   localparam int unsigned B_PSEL    = 1;
   localparam int unsigned B_ACT     = 4;
   localparam int unsigned B_CAUSE   = 5;
   localparam int unsigned B_RESTART = 6;
   localparam int unsigned B_FORCE   = 7;
   localparam int unsigned B_LOCK    = 8;
   localparam int unsigned B_DBGRUN  = 9;
   localparam int unsigned B_HALF    = 10;
   localparam int unsigned B_PAUSE   = 11;

   typedef struct packed {
      logic              pause_sleep;
      logic              run_in_debug;
      logic              lock;
      logic              act_reset;
      logic [PSEL_W-1:0] psel;
      logic              enable;
   } wdt_cfg_t;

   // shift amount (log2 of divide ratio) for each prescaler select value
   function automatic int unsigned tap_of(input int unsigned sel);
      case (sel)
         0: tap_of = 1;
         1: tap_of = 2;
         2: tap_of = 3;
         3: tap_of = 6;
         4: tap_of = 7;
         5: tap_of = 10;
         6: tap_of = 11;
         default: tap_of = 12;
      endcase
   endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_guard_pkg::*;
#(
   parameter int unsigned PRSC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              clr,
   input  logic [PSEL_W-1:0] psel,
   output logic              tick
);

   if (PRSC_W < MAX_TAP) begin : g_bad_width
      $error("wdt_prescaler: PRSC_W must cover the largest tap");
   end

   logic [PRSC_W-1:0]  presc_q;
   logic [NUM_SEL-1:0] tap_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            presc_q <= '0;
      else if (!run || clr)  presc_q <= '0;
      else                   presc_q <= presc_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_tap
      localparam int unsigned T = tap_of(i);
      assign tap_hit[i] = &presc_q[T-1:0];
   end

   assign tick = run & tap_hit[psel];

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (presc_q == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic tick,
   input  logic stall,
   output logic wrap,
   output logic half
);

   if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
      $error("wdt_counter: CNT_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step = en & ~clr & tick & ~stall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!en || clr) cnt_q <= '0;
      else if (step)       cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = step & (&cnt_q);
   assign half = cnt_q[CNT_W-1];

   p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !clr) |=> $stable(cnt_q));

   p_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
   import wdt_guard_pkg::*;
#(
   parameter logic [KEY_W-1:0] KEY = 16'hCA36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wdata,
   output wdt_cfg_t          cfg_q,
   output wdt_cfg_t          cfg_d,
   output logic              force_ev,
   output logic              clr_ev
);

   logic     key_ok;
   logic     wr_ok;
   wdt_cfg_t cfg_wr;
   logic     unused_bits;

   assign key_ok = (wdata[KEY_LSB +: KEY_W] == KEY);
   assign wr_ok  = wr_en & key_ok & ~cfg_q.lock;

   always_comb begin
      cfg_wr              = '0;
      cfg_wr.enable       = wdata[B_EN];
      cfg_wr.psel         = wdata[B_PSEL +: PSEL_W];
      cfg_wr.act_reset    = wdata[B_ACT];
      cfg_wr.lock         = wdata[B_LOCK];
      cfg_wr.run_in_debug = wdata[B_DBGRUN];
      cfg_wr.pause_sleep  = wdata[B_PAUSE];
   end

   assign cfg_d    = wr_ok ? cfg_wr : cfg_q;
   assign force_ev = wr_ok & wdata[B_FORCE] & wdata[B_EN];
   assign clr_ev   = wr_ok & (wdata[B_RESTART] | ~wdata[B_EN]);

   assign unused_bits = ^{wdata[15:12], wdata[B_HALF], wdata[B_CAUSE]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d;
   end

   p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wdata[KEY_LSB +: KEY_W] != KEY)) |=> $stable(cfg_q));

   p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.lock |=> cfg_q.lock);

   p_locked_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.lock && wr_en) |=> $stable(cfg_q));

endmodule

// File: rtl/wdt_action.sv
module wdt_action (
   input  logic clk,
   input  logic rst_sys_n,
   input  logic rst_ext_n,
   input  logic trig,
   input  logic act_reset,
   output logic irq,
   output logic rst_req,
   output logic cause
);

   logic irq_q, req_q, cause_q;

   always_ff @(posedge clk or negedge rst_sys_n) begin
      if (!rst_sys_n) begin
         irq_q <= 1'b0;
         req_q <= 1'b0;
      end else begin
         irq_q <= trig & ~act_reset;
         req_q <= req_q | (trig & act_reset);
      end
   end

   // cause survives system reset; only the external reset clears it
   always_ff @(posedge clk or negedge rst_ext_n) begin
      if (!rst_ext_n)             cause_q <= 1'b0;
      else if (trig && act_reset) cause_q <= 1'b1;
   end

   assign irq     = irq_q;
   assign rst_req = req_q;
   assign cause   = cause_q;

   p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_sys_n)
      req_q |=> req_q);

   p_cause_set_r6: assert property (@(posedge clk) disable iff (!rst_ext_n)
      req_q |-> cause_q);

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int unsigned      CNT_W  = 20,
   parameter int unsigned      PRSC_W = 12,
   parameter logic [KEY_W-1:0] KEY    = 16'hCA36
) (
   input  logic              clk,
   input  logic              rst_ext_n,
   input  logic              rst_sys_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   input  logic              dbg_halt,
   input  logic              cpu_sleep,
   output logic              wdt_irq,
   output logic              wdt_rst_req
);

   wdt_cfg_t cfg_q, cfg_d;
   logic     force_ev, clr_ev, tick, stall, wrap, half, cause;

   wdt_ctrl_regs #(.KEY(KEY)) u_regs (
      .clk      (clk),
      .rst_n    (rst_sys_n),
      .wr_en    (ctrl_we),
      .wdata    (ctrl_wdata),
      .cfg_q    (cfg_q),
      .cfg_d    (cfg_d),
      .force_ev (force_ev),
      .clr_ev   (clr_ev)
   );

   wdt_prescaler #(.PRSC_W(PRSC_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_sys_n),
      .run   (cfg_q.enable),
      .clr   (clr_ev),
      .psel  (cfg_q.psel),
      .tick  (tick)
   );

   assign stall = (dbg_halt & ~cfg_q.run_in_debug) | (cpu_sleep & cfg_q.pause_sleep);

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sys_n),
      .en    (cfg_q.enable),
      .clr   (clr_ev),
      .tick  (tick),
      .stall (stall),
      .wrap  (wrap),
      .half  (half)
   );

   wdt_action u_act (
      .clk       (clk),
      .rst_sys_n (rst_sys_n),
      .rst_ext_n (rst_ext_n),
      .trig      (wrap | force_ev),
      .act_reset (cfg_d.act_reset),
      .irq       (wdt_irq),
      .rst_req   (wdt_rst_req),
      .cause     (cause)
   );

   always_comb begin
      ctrl_rdata                     = '0;
      ctrl_rdata[B_EN]               = cfg_q.enable;
      ctrl_rdata[B_PSEL +: PSEL_W]   = cfg_q.psel;
      ctrl_rdata[B_ACT]              = cfg_q.act_reset;
      ctrl_rdata[B_CAUSE]            = cause;
      ctrl_rdata[B_LOCK]             = cfg_q.lock;
      ctrl_rdata[B_DBGRUN]           = cfg_q.run_in_debug;
      ctrl_rdata[B_HALF]             = half & cfg_q.enable;
      ctrl_rdata[B_PAUSE]            = cfg_q.pause_sleep;
   end

   p_irq_mode_r5: assert property (@(posedge clk) disable iff (!rst_sys_n)
      wdt_irq |-> !cfg_q.act_reset);

endmodule

// File: tb/wdt_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_guard_tb_top;

   localparam int unsigned CW  = 6;
   localparam logic [15:0] KY  = 16'hCA36;

   logic        clk = 1'b0;
   logic        rst_ext_n = 1'b0, rst_sys_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [31:0] ctrl_wdata = '0;
   logic [31:0] ctrl_rdata;
   logic        dbg_halt = 1'b0, cpu_sleep = 1'b0;
   logic        wdt_irq, wdt_rst_req;

   int n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   wdt_guard #(.CNT_W(CW)) dut_i (
      .clk(clk), .rst_ext_n(rst_ext_n), .rst_sys_n(rst_sys_n),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .dbg_halt(dbg_halt), .cpu_sleep(cpu_sleep),
      .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
   );

   function automatic int unsigned shift_of(input int unsigned s);
      case (s)
         0: return 1; 1: return 2; 2: return 3; 3: return 6;
         4: return 7; 5: return 10; 6: return 11; default: return 12;
      endcase
   endfunction

   function automatic int unsigned period(input int unsigned s);
      return 1 << (CW + shift_of(s));
   endfunction

   function automatic logic [31:0] keyed(input logic [15:0] low);
      return {KY, low};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
      @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = '0;
   endtask

   task automatic step(input int unsigned n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ext_reset();
      @(negedge clk); rst_ext_n = 1'b0; rst_sys_n = 1'b0;
      step(2); rst_ext_n = 1'b1; rst_sys_n = 1'b1; step(1);
   endtask

   task automatic sys_reset();
      @(negedge clk); rst_sys_n = 1'b0;
      step(2); rst_sys_n = 1'b1; step(1);
   endtask

   // after a start write, irq low at P-1, high at P, low at P+1
   task automatic expect_pulse(input string req, input int unsigned p);
      step(p - 1); chk({req, " before"}, 32'(wdt_irq), 32'd0);
      step(1);     chk({req, " at"},     32'(wdt_irq), 32'd1);
      step(1);     chk({req, " after"},  32'(wdt_irq), 32'd0);
   endtask

   task automatic count_irq(input int unsigned n, output int unsigned seen);
      seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (wdt_irq) seen++;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("[TB] FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int unsigned seen;
      int unsigned r;
      logic [31:0] d;
      void'($urandom(32'd1234));
      ext_reset();

      // R1 reset state
      chk("R1 rdata", ctrl_rdata, 32'h0);
      chk("R1 irq", 32'(wdt_irq), 32'd0);
      chk("R1 rst_req", 32'(wdt_rst_req), 32'd0);

      // R3 random readback, enable off, strobes and lock masked
      for (int i = 0; i < 16; i++) begin
         d = keyed(16'($urandom()) & 16'h0A1E | 16'($urandom()) & 16'h00C0 & 16'h0040);
         wr(d);
         chk("R3 readback", ctrl_rdata, d & 32'h0000_0A1E);
      end
      // R2 wrong key ignored
      wr(keyed(16'h0A1E));
      for (int i = 0; i < 8; i++) begin
         r = $urandom();
         d = {16'(r), 16'h0000};
         if (d[31:16] == KY) d[31:16] = 16'h1111;
         wr(d);
         chk("R2 bad key", ctrl_rdata, 32'h0000_0A1E);
      end
      wr(keyed(16'h0000));
      chk("R2 upper zero", ctrl_rdata & 32'hFFFF_0000, 32'h0);

      // R4 exact periods, directed plus random selects
      for (int s = 0; s < 3; s++) begin
         wr(keyed(16'(s << 1) | 16'h1));
         expect_pulse("R4 period", period(s));
         wr(keyed(16'h0));
      end
      for (int i = 0; i < 3; i++) begin
         r = $urandom_range(4, 0);
         wr(keyed(16'(r << 1) | 16'h1));
         expect_pulse("R4 random period", period(r));
         wr(keyed(16'h0));
      end

      // R5 wrap gives second pulse one period later
      wr(keyed(16'h1));
      expect_pulse("R5 first", period(0));
      expect_pulse("R5 second", period(0) - 1);
      wr(keyed(16'h0));

      // R12 half flag
      wr(keyed(16'h3));
      step(period(1) / 2 - 1);
      chk("R12 half before", 32'(ctrl_rdata[10]), 32'd0);
      step(1);
      chk("R12 half at", 32'(ctrl_rdata[10]), 32'd1);

      // R7 restart postpones
      wr(keyed(16'h1));
      step(100);
      wr(keyed(16'h41));
      chk("R3 strobe reads zero", ctrl_rdata & 32'h0000_00C0, 32'h0);
      expect_pulse("R7 restart", period(0));

      // R13 disable then re-enable
      step(50);
      wr(keyed(16'h0));
      chk("R13 half cleared", 32'(ctrl_rdata[10]), 32'd0);
      wr(keyed(16'h1));
      expect_pulse("R13 reenable", period(0));
      wr(keyed(16'h0));

      // R10 debug stall
      dbg_halt = 1'b1;
      wr(keyed(16'h1));
      count_irq(300, seen);
      chk("R10 stalled no irq", 32'(seen), 32'd0);
      chk("R10 stalled half", 32'(ctrl_rdata[10]), 32'd0);
      wr(keyed(16'h201));
      expect_pulse("R10 run in debug", period(0));
      dbg_halt = 1'b0;
      wr(keyed(16'h0));

      // R11 sleep pause
      cpu_sleep = 1'b1;
      wr(keyed(16'h801));
      count_irq(300, seen);
      chk("R11 paused no irq", 32'(seen), 32'd0);
      wr(keyed(16'h001));
      expect_pulse("R11 pause off", period(0));
      cpu_sleep = 1'b0;
      wr(keyed(16'h0));

      // R8 force in interrupt mode
      wr(keyed(16'h81));
      chk("R8 force irq", 32'(wdt_irq), 32'd1);
      step(1);
      chk("R8 force pulse ends", 32'(wdt_irq), 32'd0);
      wr(keyed(16'h0));

      // R6 timeout in reset mode
      wr(keyed(16'h11));
      step(period(0) - 1);
      chk("R6 req before", 32'(wdt_rst_req), 32'd0);
      step(1);
      chk("R6 req at", 32'(wdt_rst_req), 32'd1);
      chk("R6 cause", 32'(ctrl_rdata[5]), 32'd1);
      step(5);
      chk("R6 req held", 32'(wdt_rst_req), 32'd1);
      sys_reset();
      chk("R6 req cleared", 32'(wdt_rst_req), 32'd0);
      chk("R6 cause survives", ctrl_rdata, 32'h0000_0020);

      // R9 lock, then writes ignored, cleared by system reset
      wr(keyed(16'h0102));
      chk("R9 locked", ctrl_rdata, 32'h0000_0122);
      wr(keyed(16'h0091));
      chk("R9 write ignored", ctrl_rdata, 32'h0000_0122);
      chk("R9 force ignored", 32'(wdt_rst_req | wdt_irq), 32'd0);
      sys_reset();
      chk("R9 unlocked", ctrl_rdata, 32'h0000_0020);

      // R8 force in reset mode
      wr(keyed(16'h91));
      chk("R8 force reset", 32'(wdt_rst_req), 32'd1);
      sys_reset();

      // R6 external reset clears cause
      ext_reset();
      chk("R6 cause cleared", ctrl_rdata, 32'h0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule